// File: doc/BRIEF.md
# Third-Order Cascaded Sigma-Delta Modulator

This block turns an unsigned fractional control word into a short stream of small signed integers whose running average equals the fraction, with the error between the two pushed toward high frequencies. It chains three identical first-order stages. Each stage is a wrapping accumulator. Its overflow bit is that stage's coarse decision, and its remainder becomes the input of the following stage.

The three decision streams are time-aligned and combined through first- and second-difference filters. The noise of the whole cascade is therefore shaped by a third-order difference, and the wanted signal passes with unit gain. Registers between the stages keep every adder short. Delay taps on the earlier decision streams restore the alignment that the recombination needs.

A one-bit dither input, gated by an enable, can be added at the least significant bit of the first stage. Its purpose is to break up idle tones that appear for constant inputs with a small rational denominator. A clock enable pauses the whole modulator, and a synchronous reset returns it to a zero state.

Top module: `mash111_mod`

## Requirements
- R1: While `rst` is high at a rising clock edge, all accumulators, decision taps and `y_out` are cleared, so `y_out` reads 0 on the following cycle.
- R2: On each enabled edge, the first stage adds `frac_in` to its stored remainder, plus one more when both `dith_en` and `dith_bit` are 1. The carry out of bit ACC_W is that stage's decision (0 or 1), and the low ACC_W bits are the new remainder.
- R3: The second stage accumulates the first stage's stored remainder, and the third stage accumulates the second stage's stored remainder. Each produces a 0/1 carry decision in the same way as the first stage.
- R4: Write d1, d2, d3 for the stage decisions indexed by the ideal (zero-latency) cascade step n. The combined value is Y[n] = d1[n] + d2[n] − d2[n−1] + d3[n] − 2·d3[n−1] + d3[n−2]. After the k-th enabled edge following reset (k counted from 0), `y_out` holds Y[k−3], with Y of a negative index equal to 0.
- R5: `y_out` is a 4-bit two's-complement value, and every value it takes lies in −3 to +4.
- R6: While `en` is low, no state changes and `y_out` keeps its value.
- R7: When `dith_en` is 0, `dith_bit` has no effect on the output sequence.
- R8: For a constant `frac_in` = x with dither off, the sum of Y[0] to Y[2^ACC_W − 1] after reset lies in x−1 to x+2. The only error comes from the end state of the difference filters. For x = 0 the output is 0 at all times.
- R9: The full-scale word 2^ACC_W − 1 combined with an active dither bit is handled. The first-stage addend then equals 2^ACC_W, which yields a carry of 1 and an unchanged remainder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the whole modulator |
| frac_in | input | ACC_W | Unsigned fractional input word |
| dith_en | input | 1 | Enables the first-stage dither bit |
| dith_bit | input | 1 | One-bit dither value, e.g. from an LFSR |
| y_out | output | 4 | Signed combined output, range −3 to +4 |

## Verification
The hardest case to reach from the ports is a first-stage addend exactly equal to 2^ACC_W. There the remainder does not move but a carry must still come out. It occurs only when a full-scale input word meets a dither bit of 1 with dither enabled. The stimulus holds `frac_in` at all ones and drives the dither from a bench LFSR, so that case recurs many times. A reference cascade model in the scoreboard predicts every output sample, including the three-cycle alignment. Constant-input runs of exactly 2^ACC_W samples check the average against the input word.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int unsigned OUT_W   = 4;
  localparam int signed   OUT_MIN = -3;
  localparam int signed   OUT_MAX = 4;
  typedef logic signed [OUT_W-1:0] mash_out_t;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int unsigned ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] addend,
  input  logic             cin,
  output logic [ACC_W-1:0] residue,
  output logic             carry
);
  localparam int unsigned SUM_W = ACC_W + 1;

  logic [SUM_W-1:0] sum_w;
  logic             addend_nz;

  assign sum_w     = {1'b0, residue} + {1'b0, addend} + SUM_W'(cin);
  assign addend_nz = (addend != '0) || cin;

  always_ff @(posedge clk) begin
    if (rst) begin
      residue <= '0;
      carry   <= 1'b0;
    end else if (en) begin
      residue <= sum_w[ACC_W-1:0];
      carry   <= sum_w[ACC_W];
    end
  end

  // R2 / R3 / R9: the carry marks a wrap of the stored remainder
  a_r2_carry_wrap: assert property (@(posedge clk) disable iff (rst)
    en |=> (carry == ((residue < $past(residue)) ||
                      ((residue == $past(residue)) && $past(addend_nz)))));

  // R6: no enable, no change
  a_r6_acc_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(residue) && $stable(carry)));
endmodule

// File: rtl/mash_tap_line.sv
module mash_tap_line #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned WIDTH = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [WIDTH-1:0]            din,
  output logic [DEPTH:0][WIDTH-1:0]   taps
);
  logic [WIDTH-1:0] hold_r [1:DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= DEPTH; i++) hold_r[i] <= '0;
    end else if (en) begin
      hold_r[1] <= din;
      for (int i = 2; i <= DEPTH; i++) hold_r[i] <= hold_r[i-1];
    end
  end

  assign taps[0] = din;
  for (genvar g = 1; g <= DEPTH; g++) begin : g_tap
    assign taps[g] = hold_r[g];
  end

  // R4: the first tap follows the input one enabled edge later
  a_r4_tap_shift: assert property (@(posedge clk) disable iff (rst)
    en |=> (taps[1] == $past(din)));
endmodule

// File: rtl/mash_recombine.sv
module mash_recombine
  import mash_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      d1_now,
  input  logic      d2_now,
  input  logic      d2_prev,
  input  logic      d3_now,
  input  logic      d3_prev,
  input  logic      d3_prev2,
  output mash_out_t y_q
);
  mash_out_t y_next;

  always_comb begin
    y_next = mash_out_t'(d1_now)
           + mash_out_t'(d2_now) - mash_out_t'(d2_prev)
           + mash_out_t'(d3_now) - mash_out_t'({d3_prev, 1'b0})
           + mash_out_t'(d3_prev2);
  end

  always_ff @(posedge clk) begin
    if (rst)     y_q <= '0;
    else if (en) y_q <= y_next;
  end

  // R5: output range
  a_r5_range: assert property (@(posedge clk) disable iff (rst)
    (y_q >= OUT_MIN) && (y_q <= OUT_MAX));

  // R6: output held without enable
  a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y_q));
endmodule

// File: rtl/mash111_mod.sv
module mash111_mod
  import mash_pkg::*;
#(
  parameter int unsigned ACC_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        frac_in,
  input  logic                    dith_en,
  input  logic                    dith_bit,
  output logic signed [OUT_W-1:0] y_out
);
  localparam int unsigned N_STAGE  = 3;
  localparam int unsigned TAP_DEPTH = N_STAGE - 1;

  logic [ACC_W-1:0] stage_in  [N_STAGE];
  logic [ACC_W-1:0] stage_res [N_STAGE];
  logic             stage_cy  [N_STAGE];
  logic             stage_ci  [N_STAGE];

  logic [TAP_DEPTH:0][0:0] t1, t2, t3;
  mash_out_t y_int;

  assign stage_in[0] = frac_in;
  assign stage_ci[0] = dith_en & dith_bit;

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    if (s > 0) begin : g_chain
      assign stage_in[s] = stage_res[s-1];
      assign stage_ci[s] = 1'b0;
    end
    mash_acc_stage #(.ACC_W(ACC_W)) i_stage (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .addend (stage_in[s]),
      .cin    (stage_ci[s]),
      .residue(stage_res[s]),
      .carry  (stage_cy[s])
    );
  end

  // Stage s decides one cycle later than stage s-1; taps realign them.
  mash_tap_line #(.DEPTH(TAP_DEPTH), .WIDTH(1)) i_tap1 (
    .clk(clk), .rst(rst), .en(en), .din(stage_cy[0]), .taps(t1));
  mash_tap_line #(.DEPTH(TAP_DEPTH), .WIDTH(1)) i_tap2 (
    .clk(clk), .rst(rst), .en(en), .din(stage_cy[1]), .taps(t2));
  mash_tap_line #(.DEPTH(TAP_DEPTH), .WIDTH(1)) i_tap3 (
    .clk(clk), .rst(rst), .en(en), .din(stage_cy[2]), .taps(t3));

  mash_recombine i_comb (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .d1_now  (t1[2]),
    .d2_now  (t2[1]),
    .d2_prev (t2[2]),
    .d3_now  (t3[0]),
    .d3_prev (t3[1]),
    .d3_prev2(t3[2]),
    .y_q     (y_int)
  );

  assign y_out = y_int;

  // R1: reset clears the output on the next cycle
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (y_out == '0));
endmodule

// File: tb/test_mash111_mod.sv
`timescale 1ns/1ps
module test_mash111_mod;
  localparam int W    = 10;
  localparam int FULL = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [W-1:0] frac = '0;
  logic dith_en = 1'b0;
  logic dith_bit = 1'b0;
  logic signed [3:0] y;

  mash111_mod #(.ACC_W(W)) i_mash111_mod (
    .clk(clk), .rst(rst), .en(en), .frac_in(frac),
    .dith_en(dith_en), .dith_bit(dith_bit), .y_out(y));

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  string cur_tag = "R4";
  logic run = 1'b0;
  logic done = 1'b0;

  // reference cascade state
  int m_a1, m_a2, m_a3, m_d2p, m_d3p, m_d3pp;
  // monitor state
  logic mon_en, mon_rst;
  logic signed [3:0] prev_y = '0;
  int pop_idx = 0;
  int win_sum = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  // Reference step from the requirements (R2, R3, R4)
  function automatic int model_step(input int x, input int d);
    int s1, s2, s3, c1, c2, c3, r;
    s1 = m_a1 + x + d;   c1 = s1 >> W; m_a1 = s1 % FULL;
    s2 = m_a2 + m_a1;    c2 = s2 >> W; m_a2 = s2 % FULL;
    s3 = m_a3 + m_a2;    c3 = s3 >> W; m_a3 = s3 % FULL;
    r = c1 + c2 - m_d2p + c3 - 2 * m_d3p + m_d3pp;
    m_d2p = c2; m_d3pp = m_d3p; m_d3p = c3;
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; run = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(y == 0, "R1 reset state", int'(y), 0);
    exp_q.delete();
    m_a1 = 0; m_a2 = 0; m_a3 = 0; m_d2p = 0; m_d3p = 0; m_d3pp = 0;
    pop_idx = 0; win_sum = 0; prev_y = '0;
    for (int i = 0; i < 3; i++) exp_q.push_back(0);
    rst = 1'b0; run = 1'b1;
  endtask

  // driver: applies one cycle of stimulus and pushes the expected item
  task automatic drive(input int x, input bit e, input bit de, input bit db);
    @(negedge clk);
    frac = W'(x); en = e; dith_en = de; dith_bit = db;
    if (e) exp_q.push_back(model_step(x, int'(de & db)));
  endtask

  // monitor: compares the design output with the scoreboard
  always @(posedge clk) begin
    mon_en = en;
    mon_rst = rst;
    #1;
    if (run && !mon_rst) begin
      if (mon_en) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 scoreboard empty", int'(y), 0);
        end else begin
          int e_v;
          e_v = exp_q.pop_front();
          chk(int'(y) == e_v, cur_tag, int'(y), e_v);
          chk(int'(y) >= -3 && int'(y) <= 4, "R5 range", int'(y), 0);
          if (pop_idx >= 3 && pop_idx < 3 + FULL) win_sum += int'(y);
          pop_idx++;
        end
      end else begin
        chk(y == prev_y, "R6 hold", int'(y), int'(prev_y));
      end
      prev_y = y;
    end
  end

  task automatic const_run(input int x, input string tag);
    do_reset();
    cur_tag = tag;
    for (int i = 0; i < FULL + 3; i++) drive(x, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk(win_sum >= x - 1 && win_sum <= x + 2, "R8 mean window", win_sum, x);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 from power-up, then zero input stays zero (R8)
    do_reset();
    cur_tag = "R8 zero input";
    for (int i = 0; i < 200; i++) drive(0, 1'b1, 1'b0, 1'b0);

    // constant inputs over one full period (R8, R4)
    const_run(1, "R4 const x=1");
    const_run(341, "R4 const x=341");
    const_run(512, "R4 const x=512");
    const_run(FULL - 1, "R9 const full scale");

    // varying input with enable gaps (R6, R3)
    do_reset();
    cur_tag = "R3 ramp with gaps";
    for (int i = 0; i < 1500; i++) begin
      lfsr_step();
      drive((i * 37) % FULL, lfsr[0] | lfsr[3], 1'b0, 1'b0);
    end

    // dither enabled (R2)
    do_reset();
    cur_tag = "R2 dither on";
    for (int i = 0; i < 1200; i++) begin
      lfsr_step();
      drive(100, 1'b1, 1'b1, lfsr[0]);
    end

    // full scale with dither: addend equals 2^W (R9)
    do_reset();
    cur_tag = "R9 full scale dither";
    for (int i = 0; i < 1200; i++) begin
      lfsr_step();
      drive(FULL - 1, 1'b1, 1'b1, lfsr[1]);
    end

    // dither bit toggling while disabled (R7): scoreboard ignores it
    do_reset();
    cur_tag = "R7 dither disabled";
    for (int i = 0; i < 1100; i++) begin
      lfsr_step();
      drive(205, 1'b1, 1'b0, lfsr[2]);
    end
    @(negedge clk);
    chk(win_sum >= 204 && win_sum <= 207, "R7 mean unaffected", win_sum, 205);

    // reset in the middle of activity (R1)
    do_reset();
    cur_tag = "R1 pre-reset activity";
    for (int i = 0; i < 50; i++) drive(777, 1'b1, 1'b0, 1'b0);
    do_reset();
    cur_tag = "R1 after mid-run reset";
    for (int i = 0; i < 50; i++) drive(3, 1'b1, 1'b0, 1'b0);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule